// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel video output: horizontal sync, vertical sync, a data-enable strobe and the pixel coordinates of the active area. It runs entirely in the pixel-clock domain. A simple write port loads a small register set that holds the sync, porch and active sizes, per-signal polarity inversions, a pixel-clock inversion flag, a bus-width code and the run enable.

Each line is laid out as sync pulse, back porch, active pixels and front porch, and a frame uses the same order counted in lines. Horizontal sync width and both horizontal porches are written as the length minus one. The vertical sync width is also written minus one, while the two vertical porches are written as plain line counts, so either may be zero. While the enable bit is clear, both counters are held at zero and every output stays at its inactive level. Setting the bit starts a frame at its first sync cycle.

There is no streaming data path: the write port and all outputs are plain level signals without handshake, and a write takes effect on the clock edge that samples it.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, hsync, vsync and de are 0, pos_x and pos_y are 0, pclk_invert is 0 and data_lines reports 12.
- R2: A write to address 1 sets the horizontal timing: bits 7:0 hold sync width minus 1, bits 19:8 front porch minus 1, bits 31:20 back porch minus 1 (pixel clocks).
- R3: A write to address 2 sets the vertical timing: bits 7:0 hold sync width minus 1, bits 19:8 the front porch and bits 31:20 the back porch, both as plain line counts that may be zero.
- R4: A write to address 3 sets the active area: bits 11:0 hold width minus 1 and bits 27:16 height minus 1.
- R5: Within a line, the order is sync, back porch, active, front porch, and within a frame the same order applies in whole lines. The line period is the sum of the four horizontal lengths, and the frame is the sum of the four vertical lengths in lines.
- R6: Before inversion, de is high only when both the horizontal and vertical positions lie in their active regions, and it is never high together with a raw hsync.
- R7: During active cycles, pos_x counts from 0 to width minus 1 and pos_y holds the active line index from 0. Both are 0 whenever de is inactive.
- R8: A write to address 4 sets the polarities: bit 12 inverts vsync, bit 13 inverts hsync and bit 15 inverts de. The raw sync and enable signals are active-high.
- R9: Bit 14 of the polarity register drives the pclk_invert output.
- R10: Bits 10:8 of the control register (address 0) select the bus width on data_lines: 0→12, 1→16, 2→18, 3→24, 4→30, 5→36. The unused codes 6 and 7 report 24.
- R11: Bit 0 of the control register enables the generator. While it is clear, the counters stay at zero, hsync, vsync and de sit at their inactive levels, and pos_x and pos_y are 0. In the first enabled cycle, both syncs are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 control, 1 horizontal, 2 vertical, 3 size, 4 polarity) |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pos_x | output | 12 | Active pixel column, 0 outside active |
| pos_y | output | 12 | Active line index, 0 outside active |
| pclk_invert | output | 1 | Pixel clock inversion request |
| data_lines | output | 6 | Decoded parallel bus width |

## Verification
The bound checker tests the following on every cycle:
- the idle state while the generator is disabled,
- that de and a raw hsync never overlap,
- that the coordinates stay inside the programmed active area,
- that pos_x steps by one while pos_y holds across a run of active pixels,
- that both syncs assert when the enable rises.

The actual segment lengths and the differing minus-one conventions between the horizontal and vertical fields can only be confirmed by the bench's cycle-by-cycle sweeps against arithmetically computed rasters. The same applies to the zero-length vertical porches, the polarity combinations and the bus-width code table.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int SYNC_W  = 8;
  localparam int PORCH_W = 12;
  localparam int ACT_W   = 12;
  localparam int LINES_W = 6;
  localparam int ADDR_W  = 3;
  localparam int CODE_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
  localparam logic [ADDR_W-1:0] A_VTIM = 3'd2;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd3;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd4;

  typedef struct packed {
    logic               en;
    logic [CODE_W-1:0]  lane_code;
    logic [SYNC_W-1:0]  hsw_m1;
    logic [PORCH_W-1:0] hfp_m1;
    logic [PORCH_W-1:0] hbp_m1;
    logic [SYNC_W-1:0]  vsw_m1;
    logic [PORCH_W-1:0] vfp;
    logic [PORCH_W-1:0] vbp;
    logic [ACT_W-1:0]   hact_m1;
    logic [ACT_W-1:0]   vact_m1;
    logic               inv_vs;
    logic               inv_hs;
    logic               inv_pclk;
    logic               inv_de;
  } dtg_cfg_t;

  function automatic logic [LINES_W-1:0] lines_from_code(input logic [CODE_W-1:0] c);
    case (c)
      3'd0:    return 6'd12;
      3'd1:    return 6'd16;
      3'd2:    return 6'd18;
      3'd3:    return 6'd24;
      3'd4:    return 6'd30;
      3'd5:    return 6'd36;
      default: return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
  import dtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output dtg_cfg_t          cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          cfg.en        <= wdata[0];
          cfg.lane_code <= wdata[10:8];
        end
        A_HTIM: begin
          cfg.hsw_m1 <= wdata[7:0];
          cfg.hfp_m1 <= wdata[19:8];
          cfg.hbp_m1 <= wdata[31:20];
        end
        A_VTIM: begin
          cfg.vsw_m1 <= wdata[7:0];
          cfg.vfp    <= wdata[19:8];
          cfg.vbp    <= wdata[31:20];
        end
        A_SIZE: begin
          cfg.hact_m1 <= wdata[11:0];
          cfg.vact_m1 <= wdata[27:16];
        end
        A_POL: begin
          cfg.inv_vs   <= wdata[12];
          cfg.inv_hs   <= wdata[13];
          cfg.inv_pclk <= wdata[14];
          cfg.inv_de   <= wdata[15];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int SYNC_W       = 8,
  parameter int PORCH_W      = 12,
  parameter int ACT_W        = 12,
  parameter bit PORCH_MINUS1 = 1'b1,
  parameter int CW           = PORCH_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               step,
  input  logic [SYNC_W-1:0]  sync_m1,
  input  logic [PORCH_W-1:0] bp_f,
  input  logic [PORCH_W-1:0] fp_f,
  input  logic [ACT_W-1:0]   act_m1,
  output logic               wrap,
  output logic               in_sync,
  output logic               in_act,
  output logic [ACT_W-1:0]   coord
);
  logic [CW-1:0] pos_q;
  logic [CW-1:0] sync_len, bp_len, fp_len, act_len;
  logic [CW-1:0] act_start, act_end, last_pos;

  assign sync_len = CW'(sync_m1) + CW'(1);
  assign act_len  = CW'(act_m1) + CW'(1);

  generate
    if (PORCH_MINUS1) begin : g_porch_m1
      assign bp_len = CW'(bp_f) + CW'(1);
      assign fp_len = CW'(fp_f) + CW'(1);
    end else begin : g_porch_plain
      assign bp_len = CW'(bp_f);
      assign fp_len = CW'(fp_f);
    end
  endgenerate

  assign act_start = sync_len + bp_len;
  assign act_end   = act_start + act_len;
  assign last_pos  = act_end + fp_len - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)          pos_q <= '0;
    else if (!en)        pos_q <= '0;
    else if (step) begin
      if (pos_q >= last_pos) pos_q <= '0;
      else                   pos_q <= pos_q + CW'(1);
    end
  end

  assign wrap    = en && step && (pos_q >= last_pos);
  assign in_sync = en && (pos_q < sync_len);
  assign in_act  = en && (pos_q >= act_start) && (pos_q < act_end);
  assign coord   = in_act ? (pos_q[ACT_W-1:0] - act_start[ACT_W-1:0]) : '0;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [ACT_W-1:0]   pos_x,
  output logic [ACT_W-1:0]   pos_y,
  output logic               pclk_invert,
  output logic [LINES_W-1:0] data_lines
);
  dtg_cfg_t cfg;
  logic h_wrap, h_sync, h_act;
  logic v_wrap_unused, v_sync, v_act;
  logic [ACT_W-1:0] h_crd, v_crd;
  logic de_raw;
  logic en_w, inv_hs_w, inv_vs_w, inv_de_w;
  logic [ACT_W-1:0] hact_m1_w, vact_m1_w;

  dtg_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  dtg_axis #(
    .SYNC_W(SYNC_W), .PORCH_W(PORCH_W), .ACT_W(ACT_W), .PORCH_MINUS1(1'b1)
  ) u_horiz (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .step    (1'b1),
    .sync_m1 (cfg.hsw_m1),
    .bp_f    (cfg.hbp_m1),
    .fp_f    (cfg.hfp_m1),
    .act_m1  (cfg.hact_m1),
    .wrap    (h_wrap),
    .in_sync (h_sync),
    .in_act  (h_act),
    .coord   (h_crd)
  );

  dtg_axis #(
    .SYNC_W(SYNC_W), .PORCH_W(PORCH_W), .ACT_W(ACT_W), .PORCH_MINUS1(1'b0)
  ) u_vert (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .step    (h_wrap),
    .sync_m1 (cfg.vsw_m1),
    .bp_f    (cfg.vbp),
    .fp_f    (cfg.vfp),
    .act_m1  (cfg.vact_m1),
    .wrap    (v_wrap_unused),
    .in_sync (v_sync),
    .in_act  (v_act),
    .coord   (v_crd)
  );

  assign de_raw      = h_act & v_act;
  assign hsync       = h_sync ^ cfg.inv_hs;
  assign vsync       = v_sync ^ cfg.inv_vs;
  assign de          = de_raw ^ cfg.inv_de;
  assign pos_x       = de_raw ? h_crd : '0;
  assign pos_y       = de_raw ? v_crd : '0;
  assign pclk_invert = cfg.inv_pclk;
  assign data_lines  = lines_from_code(cfg.lane_code);

  assign en_w      = cfg.en;
  assign inv_hs_w  = cfg.inv_hs;
  assign inv_vs_w  = cfg.inv_vs;
  assign inv_de_w  = cfg.inv_de;
  assign hact_m1_w = cfg.hact_m1;
  assign vact_m1_w = cfg.vact_m1;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int ACT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             en,
  input logic             inv_hs,
  input logic             inv_vs,
  input logic             inv_de,
  input logic [ACT_W-1:0] hact_m1,
  input logic [ACT_W-1:0] vact_m1,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [ACT_W-1:0] pos_x,
  input logic [ACT_W-1:0] pos_y
);
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == inv_hs && vsync == inv_vs && de == inv_de && pos_x == '0 && pos_y == '0));

  // R11
  enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (hsync != inv_hs && vsync != inv_vs));

  // R6
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de != inv_de) |-> (hsync == inv_hs));

  // R4
  coord_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de != inv_de) |-> (pos_x <= hact_m1 && pos_y <= vact_m1));

  // R7
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((de != inv_de) && $past(de != inv_de) && !$past(cfg_we) && !cfg_we)
      |-> (pos_x == $past(pos_x) + 1'b1));

  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((de != inv_de) && $past(de != inv_de) && !$past(cfg_we) && !cfg_we)
      |-> (pos_y == $past(pos_y)));
endmodule

bind disp_timing_gen dtg_checker #(.ACT_W(dtg_pkg::ACT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .en      (en_w),
  .inv_hs  (inv_hs_w),
  .inv_vs  (inv_vs_w),
  .inv_de  (inv_de_w),
  .hact_m1 (hact_m1_w),
  .vact_m1 (vact_m1_w),
  .hsync   (hsync),
  .vsync   (vsync),
  .de      (de),
  .pos_x   (pos_x),
  .pos_y   (pos_y)
);

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        hsync, vsync, de, pclk_invert;
  logic [11:0] pos_x, pos_y;
  logic [5:0]  data_lines;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  disp_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y),
    .pclk_invert(pclk_invert), .data_lines(data_lines)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {5'b0, hsync, vsync, de, pos_x, pos_y};
  endfunction

  // Program one raster, check idle, enable, compare every cycle, then disable.
  task automatic sweep(input int hs, input int hb, input int ha, input int hf,
                       input int vs, input int vb, input int va, input int vf,
                       input bit ivs, input bit ihs, input bit ide, input int frames);
    int ht, vt;
    ht = hs + hb + ha + hf;
    vt = vs + vb + va + vf;
    wr(3'd0, 32'h0);
    wr(3'd4, {16'b0, ide, 1'b0, ihs, ivs, 12'b0});
    // R2 horizontal fields minus one
    wr(3'd1, (32'(hb - 1) << 20) | (32'(hf - 1) << 8) | 32'(hs - 1));
    // R3 vertical porches plain counts
    wr(3'd2, (32'(vb) << 20) | (32'(vf) << 8) | 32'(vs - 1));
    // R4 active size minus one
    wr(3'd3, (32'(va - 1) << 16) | 32'(ha - 1));
    check("R11 idle before enable", outs(), {5'b0, ihs, ivs, ide, 24'b0});
    wr(3'd0, 32'h1);
    for (int t = 0; t < ht * vt * frames; t++) begin
      int h, v, ex, ey;
      bit rhs, rvs, rde;
      h = t % ht;
      v = (t / ht) % vt;
      rhs = (h < hs);
      rvs = (v < vs);
      rde = (h >= hs + hb) && (h < hs + hb + ha) && (v >= vs + vb) && (v < vs + vb + va);
      ex = rde ? h - hs - hb : 0;
      ey = rde ? v - vs - vb : 0;
      check("R2/R3/R4/R5/R6/R7/R8 raster", outs(),
            {5'b0, rhs ^ ihs, rvs ^ ivs, rde ^ ide, 12'(ex), 12'(ey)});
      @(negedge clk);
    end
    wr(3'd0, 32'h0);
    check("R11 idle after disable", outs(), {5'b0, ihs, ivs, ide, 24'b0});
    @(negedge clk);
    @(negedge clk);
    check("R11 idle holds", outs(), {5'b0, ihs, ivs, ide, 24'b0});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 32'h0);
    check("R1 reset pclk_invert", {31'b0, pclk_invert}, 32'h0);
    check("R1 reset data_lines", {26'b0, data_lines}, 32'd12);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 bus width code table
    for (int c = 0; c < 8; c++) begin
      int expw;
      case (c)
        0: expw = 12; 1: expw = 16; 2: expw = 18; 3: expw = 24;
        4: expw = 30; 5: expw = 36; default: expw = 24;
      endcase
      wr(3'd0, 32'(c) << 8);
      check("R10 data_lines code", {26'b0, data_lines}, 32'(expw));
      check("R10 code write keeps idle", outs(), 32'h0);
    end

    // R9 pixel clock inversion bit
    wr(3'd4, 32'h0000_4000);
    check("R9 pclk_invert set", {31'b0, pclk_invert}, 32'h1);
    check("R9 bit14 leaves syncs", outs(), 32'h0);
    wr(3'd4, 32'h0);
    check("R9 pclk_invert clear", {31'b0, pclk_invert}, 32'h0);

    // R5 typical raster, no inversion
    sweep(2, 3, 5, 2, 1, 2, 3, 1, 1'b0, 1'b0, 1'b0, 2);
    // R3 zero vertical porches, all polarities inverted (R8)
    sweep(1, 1, 3, 1, 2, 0, 2, 0, 1'b1, 1'b1, 1'b1, 2);
    // R8 mixed polarity, single-cycle porches and wider sync
    sweep(3, 1, 4, 1, 1, 1, 2, 2, 1'b0, 1'b1, 1'b0, 1);
    // R6 single-pixel active width
    sweep(1, 2, 1, 3, 1, 1, 1, 1, 1'b1, 1'b0, 1'b1, 2);

    summary();
    $finish;
  end
endmodule